// File: doc/BRIEF.md
# Capacitor Precharge Sequencer

This block brings the eight film capacitors of a stacked switched-capacitor energy buffer to their starting voltages before the buffer enters its run mode. It works through a fixed list of steps, one capacitor per step. In each step it drives a set of switch enables that routes an external current source into one capacitor. It also puts out the comparator reference code for that capacitor's target, and then waits for the synchronized comparator flag to report that the target has been reached.

The six supporting capacitors are charged first, from the highest target down to the one whose target is zero. The two backbone capacitors follow, and they charge through a different bridge leg. When the last step finishes, every switch is opened, which also disconnects the source. A sticky done flag then hands control to the run-mode state machine. The enable vector never moves directly from one switch pattern to another: a single all-off cycle always separates two steps.

Top module: `pchg_seq`

## Requirements
- R1: After reset, and until start_i is seen high, all switch enables are 0, done_o is 0, cap_idx_o is 0 and ref_code_o is 0, whatever reached_i does.
- R2: Steps run in a fixed order. cap_idx_o is 0 to 5 for the supporting capacitors (highest target first) and 6 and 7 for the two backbone capacitors. The selector enable of the active step is bit cap_idx_o, and exactly one of bits 7:0 is high while a step is active.
- R3: Enable bit layout. Bits 0 to 7 are the capacitor selectors, bit 9 is the backbone route leg, bit 11 is the supporting route leg, bit 12 is the supporting return switch, and bit 13 closes both source isolation switches. During a supporting step k, the vector is exactly bits k, 11, 12 and 13 (0x3800 | 1<<k).
- R4: During a backbone step k (6 or 7), the vector is exactly bits k, 9 and 13 (0x2200 | 1<<k). Bits 8 and 10, the unused bridge legs, are never set.
- R5: ref_code_o equals NOM_CODE*tenths/10 for the active step's target, where tenths is 5,4,3,2,1,0 for supporting steps 0 to 5 and 4 for both backbone steps. With NOM_CODE=200 this gives 100,80,60,40,20,0,80,80. The code is 0 when no step is active.
- R6: The comparator passes through a two-flop synchronizer and is not sampled during the first two cycles of a step. A nonzero-target step whose comparator input rises in its T-th cycle (T≥1) and then stays high lasts exactly T+2 cycles.
- R7: The zero-target step (index 5) lasts exactly one cycle, regardless of reached_i.
- R8: Exactly one all-off cycle separates two consecutive steps.
- R9: After step 7 completes, the next cycle shows all enables 0 (source isolated) and done_o high. done_o and the all-off vector then hold until reset.
- R10: start_i has no effect while a sequence is running or after done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the precharge sequence (accepted only when idle) |
| reached_i | input | 1 | Asynchronous comparator flag: sensed voltage reached the reference |
| sw_en_o | output | 14 | Switch enable vector |
| ref_code_o | output | 8 | Reference DAC code for the active target |
| cap_idx_o | output | 3 | Index of the capacitor being charged |
| done_o | output | 1 | Precharge complete, sticky until reset |

## Verification
The bound checker watches, on every cycle, the shape of the enable vector. It checks the break-before-make gap, that at most one selector is on and that it agrees with the index, that the source is closed whenever a selector is on, that the two routes are mutually exclusive, and that the zero step is short and the done state is quiet and sticky. Some properties only the bench scenarios can show: the exact step order and reference codes, how long each step lasts relative to when the comparator rises, that comparator activity during the settle window and the zero step is ignored, and that start pulses are ignored mid-sequence and after completion.

// File: rtl/pchg_pkg.sv
package pchg_pkg;
   // control bits that follow the capacitor selectors in the enable vector
   localparam int LEG_A_OFS   = 0;  // bridge leg, unused during precharge
   localparam int LEG_BB_OFS  = 1;  // backbone route leg
   localparam int LEG_C_OFS   = 2;  // bridge leg, unused during precharge
   localparam int LEG_SUP_OFS = 3;  // supporting route leg
   localparam int RET_OFS     = 4;  // supporting return switch
   localparam int ISO_OFS     = 5;  // source isolation pair
   localparam int CTRL_BITS   = 6;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_SETTLE,
      PS_CHARGE,
      PS_GAP,
      PS_DONE
   } pchg_state_e;
endpackage

// File: rtl/pchg_sync.sv
module pchg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pchg_step_rom.sv
module pchg_step_rom #(
   parameter int NUM_SUP   = 6,
   parameter int NUM_BB    = 2,
   parameter int REF_W     = 8,
   parameter int NOM_CODE  = 200,
   parameter int BB_TENTHS = 4,
   localparam int NUM_CAP  = NUM_SUP + NUM_BB,
   localparam int IDX_W    = $clog2(NUM_CAP),
   localparam int SW_W     = NUM_CAP + pchg_pkg::CTRL_BITS
) (
   input  logic [IDX_W-1:0] step_i,
   output logic [SW_W-1:0]  pat_o,
   output logic [REF_W-1:0] code_o,
   output logic             zero_o
);
   import pchg_pkg::*;

   localparam int BB_RT_B  = NUM_CAP + LEG_BB_OFS;
   localparam int SUP_RT_B = NUM_CAP + LEG_SUP_OFS;
   localparam int RET_B    = NUM_CAP + RET_OFS;
   localparam int ISO_B    = NUM_CAP + ISO_OFS;

   logic [SW_W-1:0]  tbl_pat  [NUM_CAP];
   logic [REF_W-1:0] tbl_code [NUM_CAP];
   logic             tbl_zero [NUM_CAP];

   for (genvar i = 0; i < NUM_CAP; i++) begin : g_step
      localparam bit IS_SUP = (i < NUM_SUP);
      localparam int TENTHS = IS_SUP ? (NUM_SUP - 1 - i) : BB_TENTHS;
      localparam logic [SW_W-1:0] ROUTE = IS_SUP ?
         ((SW_W'(1) << SUP_RT_B) | (SW_W'(1) << RET_B)) : (SW_W'(1) << BB_RT_B);
      localparam logic [SW_W-1:0] PAT = (SW_W'(1) << i) | (SW_W'(1) << ISO_B) | ROUTE;
      assign tbl_pat[i]  = PAT;
      assign tbl_code[i] = REF_W'((NOM_CODE * TENTHS) / 10);
      assign tbl_zero[i] = (TENTHS == 0);
   end

   assign pat_o  = tbl_pat[step_i];
   assign code_o = tbl_code[step_i];
   assign zero_o = tbl_zero[step_i];
endmodule

// File: rtl/pchg_ctrl.sv
module pchg_ctrl #(
   parameter int NUM_CAP    = 8,
   parameter int SETTLE_CYC = 2,
   localparam int IDX_W     = $clog2(NUM_CAP),
   localparam int CNT_W     = $clog2(SETTLE_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             reached_s_i,
   input  logic             zero_tgt_i,
   output logic [IDX_W-1:0] step_o,
   output logic             active_o,
   output logic             done_o
);
   import pchg_pkg::*;

   pchg_state_e      state_q, state_d;
   logic [IDX_W-1:0] step_q, step_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             last_step;

   assign last_step = (step_q == IDX_W'(NUM_CAP - 1));

   always_comb begin
      state_d = state_q;
      step_d  = step_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         PS_IDLE: if (start_i) begin
            state_d = PS_SETTLE;
            step_d  = '0;
            cnt_d   = '0;
         end
         PS_SETTLE: begin
            if (zero_tgt_i)                             state_d = last_step ? PS_DONE : PS_GAP;
            else if (cnt_q == CNT_W'(SETTLE_CYC - 1))   state_d = PS_CHARGE;
            else                                        cnt_d   = cnt_q + 1'b1;
         end
         PS_CHARGE: if (reached_s_i) state_d = last_step ? PS_DONE : PS_GAP;
         PS_GAP: begin
            state_d = PS_SETTLE;
            step_d  = step_q + 1'b1;
            cnt_d   = '0;
         end
         PS_DONE: state_d = PS_DONE;
         default: state_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_IDLE;
         step_q  <= '0;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         step_q  <= step_d;
         cnt_q   <= cnt_d;
      end
   end

   assign step_o   = step_q;
   assign active_o = (state_q == PS_SETTLE) || (state_q == PS_CHARGE);
   assign done_o   = (state_q == PS_DONE);
endmodule

// File: rtl/pchg_seq.sv
module pchg_seq #(
   parameter int NUM_SUP     = 6,
   parameter int NUM_BB      = 2,
   parameter int REF_W       = 8,
   parameter int NOM_CODE    = 200,
   parameter int BB_TENTHS   = 4,
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE_CYC  = 2
) (
   input  logic                                              clk,
   input  logic                                              rst_n,
   input  logic                                              start_i,
   input  logic                                              reached_i,
   output logic [NUM_SUP+NUM_BB+pchg_pkg::CTRL_BITS-1:0]     sw_en_o,
   output logic [REF_W-1:0]                                  ref_code_o,
   output logic [$clog2(NUM_SUP+NUM_BB)-1:0]                 cap_idx_o,
   output logic                                              done_o
);
   localparam int NUM_CAP = NUM_SUP + NUM_BB;
   localparam int IDX_W   = $clog2(NUM_CAP);
   localparam int SW_W    = NUM_CAP + pchg_pkg::CTRL_BITS;

   initial begin
      if (SYNC_STAGES < 2)          $fatal(1, "pchg_seq: SYNC_STAGES must be at least 2");
      if (SETTLE_CYC < SYNC_STAGES) $fatal(1, "pchg_seq: SETTLE_CYC must cover the synchronizer depth");
      if (NUM_CAP != (1 << IDX_W))  $fatal(1, "pchg_seq: capacitor count must be a power of two");
      if (NOM_CODE * 10 / 10 >= (1 << REF_W) * 2) $fatal(1, "pchg_seq: NOM_CODE too wide for REF_W");
   end

   logic             reached_s;
   logic             zero_tgt;
   logic             active;
   logic [IDX_W-1:0] step;
   logic [SW_W-1:0]  step_pat;
   logic [REF_W-1:0] step_code;

   pchg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (reached_i),
      .q_o   (reached_s)
   );

   pchg_step_rom #(
      .NUM_SUP   (NUM_SUP),
      .NUM_BB    (NUM_BB),
      .REF_W     (REF_W),
      .NOM_CODE  (NOM_CODE),
      .BB_TENTHS (BB_TENTHS)
   ) u_rom (
      .step_i (step),
      .pat_o  (step_pat),
      .code_o (step_code),
      .zero_o (zero_tgt)
   );

   pchg_ctrl #(
      .NUM_CAP    (NUM_CAP),
      .SETTLE_CYC (SETTLE_CYC)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .reached_s_i (reached_s),
      .zero_tgt_i  (zero_tgt),
      .step_o      (step),
      .active_o    (active),
      .done_o      (done_o)
   );

   assign sw_en_o    = active ? step_pat  : '0;
   assign ref_code_o = active ? step_code : '0;
   assign cap_idx_o  = step;
endmodule

// File: rtl/pchg_seq_chk.sv
module pchg_seq_chk #(
   parameter int NUM_SUP = 6,
   parameter int NUM_BB  = 2,
   parameter int REF_W   = 8,
   localparam int NUM_CAP = NUM_SUP + NUM_BB,
   localparam int IDX_W   = $clog2(NUM_CAP),
   localparam int SW_W    = NUM_CAP + pchg_pkg::CTRL_BITS
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SW_W-1:0]  sw_en_o,
   input logic [REF_W-1:0] ref_code_o,
   input logic [IDX_W-1:0] cap_idx_o,
   input logic             done_o
);
   import pchg_pkg::*;

   logic [NUM_CAP-1:0] sel;
   assign sel = sw_en_o[NUM_CAP-1:0];

   // R8: a change between two nonzero patterns must pass through all-off
   p_bbm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sw_en_o) != '0 && sw_en_o != $past(sw_en_o)) |-> sw_en_o == '0);

   // R2: at most one selector on, and it matches the reported index
   p_one_sel_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel));
   p_idx_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != '0) |-> sel[cap_idx_o]);

   // R3: source connected whenever a capacitor is selected; routes exclusive
   p_iso_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != '0) |-> sw_en_o[NUM_CAP + ISO_OFS]);
   p_route_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_en_o[NUM_CAP + LEG_BB_OFS] && sw_en_o[NUM_CAP + LEG_SUP_OFS]));

   // R4: unused bridge legs stay open
   p_legs_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en_o[NUM_CAP + LEG_A_OFS] && !sw_en_o[NUM_CAP + LEG_C_OFS]);

   // R7: the zero-target selector is on for one cycle with a zero code
   p_zero_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sel[NUM_SUP-1] |=> !sel[NUM_SUP-1]);
   p_zero_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sel[NUM_SUP-1] |-> ref_code_o == '0);

   // R9: done is quiet and sticky
   p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> sw_en_o == '0);
   p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o);
endmodule

bind pchg_seq pchg_seq_chk #(
   .NUM_SUP (NUM_SUP),
   .NUM_BB  (NUM_BB),
   .REF_W   (REF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sw_en_o    (sw_en_o),
   .ref_code_o (ref_code_o),
   .cap_idx_o  (cap_idx_o),
   .done_o     (done_o)
);

// File: tb/pchg_seq_tb.sv
module pchg_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        reached_i = 1'b0;
   logic [13:0] sw_en_o;
   logic [7:0]  ref_code_o;
   logic [2:0]  cap_idx_o;
   logic        done_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;
   int tt [8];

   always #2 clk = ~clk;  // 250 MHz

   pchg_seq u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .reached_i  (reached_i),
      .sw_en_o    (sw_en_o),
      .ref_code_o (ref_code_o),
      .cap_idx_o  (cap_idx_o),
      .done_o     (done_o)
   );

   // expected values from the requirements
   function automatic logic [13:0] exp_pat(input int k);
      if (k < 6) return 14'h3800 | (14'h1 << k);   // R3
      else       return 14'h2200 | (14'h1 << k);   // R4
   endfunction

   function automatic int exp_tenths(input int k);
      return (k < 6) ? (5 - k) : 4;
   endfunction

   function automatic int exp_code(input int k);
      return (200 * exp_tenths(k)) / 10;            // R5
   endfunction

   function automatic int exp_dur(input int k, input int t);
      return (exp_tenths(k) == 0) ? 1 : t + 2;      // R6, R7
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; start_i = 1'b0; reached_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one full sequence; poke pulses start during step 3 (R10)
   task automatic run_seq(input bit poke);
      start_i = 1'b1;
      for (int k = 0; k < 8; k++) begin
         int n = 0;
         @(negedge clk);
         start_i = 1'b0;
         chk(sw_en_o == exp_pat(k), (k < 6) ? "R3 pattern" : "R4 pattern", sw_en_o, exp_pat(k));
         chk(int'(ref_code_o) == exp_code(k), "R5 code", ref_code_o, exp_code(k));
         chk(int'(cap_idx_o) == k, "R2 index", cap_idx_o, k);
         while (sw_en_o == exp_pat(k) && n < 200) begin
            n++;
            if (exp_tenths(k) == 0) reached_i = 1'($urandom % 2);  // ignored, R7
            else if (n >= tt[k])    reached_i = 1'b1;
            if (poke && k == 3) start_i = (n == 1);
            @(negedge clk);
         end
         start_i   = 1'b0;
         reached_i = 1'b0;
         chk(n == exp_dur(k, tt[k]), (k == 5) ? "R7 zero step length" : "R6 step length", n, exp_dur(k, tt[k]));
         if (k < 7) chk(sw_en_o == 14'h0 && !done_o, "R8 gap", sw_en_o, 0);
         else       chk(sw_en_o == 14'h0 && done_o, "R9 done", {done_o, sw_en_o}, 15'h4000);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0c11));
      do_reset();
      // R1: reset state, and comparator activity while idle has no effect
      chk(sw_en_o == 14'h0, "R1 enables", sw_en_o, 0);
      chk(!done_o, "R1 done", done_o, 0);
      chk(cap_idx_o == 3'd0, "R1 index", cap_idx_o, 0);
      chk(ref_code_o == 8'd0, "R1 code", ref_code_o, 0);
      for (int i = 0; i < 12; i++) begin
         reached_i = ~reached_i;
         @(negedge clk);
         chk(sw_en_o == 14'h0 && !done_o, "R1 idle", sw_en_o, 0);
      end
      reached_i = 1'b0;
      repeat (3) @(negedge clk);

      // directed: shortest comparator response, start poked mid-run (R10)
      for (int k = 0; k < 8; k++) tt[k] = 1;
      run_seq(1'b1);
      // R9/R10: start after done changes nothing
      start_i = 1'b1; reached_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(done_o && sw_en_o == 14'h0, "R10 start after done", {done_o, sw_en_o}, 15'h4000);
      end

      // directed: long responses
      do_reset();
      for (int k = 0; k < 8; k++) tt[k] = 40;
      run_seq(1'b0);

      // random response times
      for (int r = 0; r < 6; r++) begin
         do_reset();
         for (int k = 0; k < 8; k++) tt[k] = 1 + int'($urandom % 25);
         run_seq(r[0]);
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule